// File: doc/BRIEF.md
# Thresholded Count-and-Sum Unit

This unit is a small controller with its own datapath. After a start pulse it clears two accumulators, then takes unsigned 8-bit samples one at a time through a valid/ready pair. Only a sample strictly above 10 is used. For each such sample, the tally goes up by one and the sample is added to the total, both in the same clock cycle. Samples of 10 or below are read and then dropped.

The test for the end of the stream comes after the sample has been handled. The run ends with the first zero sample, and a zero is never counted because it fails the threshold test. The unit then raises `done` for one cycle. The total and tally stay on the outputs until the next start. Both accumulators are 8 bits wide and wrap modulo 256.

Top module: `thresh_tally`

## Requirements
- R1: After reset, `busy`, `done` and `in_ready` are 0, and `sum_out` and `cnt_out` are 0.
- R2: A `start` pulse while `busy` is 0 clears `sum_out` and `cnt_out` to 0 on the same edge. On that edge the unit enters the reading step, where `in_ready` is 1.
- R3: A sample is counted and added only when its value is strictly greater than 10. A value of 11 is used, and values 0 to 10 leave both outputs unchanged.
- R4: For a used sample, `cnt_out` and `sum_out` change together in the same cycle, which is the second rising edge after the sample is accepted.
- R5: A zero sample ends the run after it has been processed. `done` is high for exactly one cycle, and in that cycle the outputs show the final total and tally.
- R6: Once the unit is idle, `sum_out` and `cnt_out` hold their values until the next `start`.
- R7: `sum_out` and `cnt_out` wrap modulo 256 when they overflow.
- R8: A sample is accepted only on an edge where both `in_valid` and `in_ready` are 1. `in_valid` has no effect when `in_ready` is 0, including while the unit is idle.
- R9: A `start` pulse while `busy` is 1 has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the unit is idle |
| in_valid | input | 1 | Qualifies `in_x` |
| in_x | input | 8 | Unsigned sample |
| in_ready | output | 1 | The unit is waiting for a sample |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: results are final |
| sum_out | output | 8 | Total of the samples above 10 |
| cnt_out | output | 8 | Number of samples above 10 |

## Verification
The bench sends every value from 1 to 255 as a one-sample run, followed by a zero. A comparator written as `>=` or with the wrong constant would then show a wrong tally at 10 or 11. Other runs check the following faults:
- Repeated 11s past 256 entries and large sums expose an accumulator that saturates instead of wrapping.
- A spurious `in_valid` during the update step, and another while idle, expose a datapath that accepts a sample without the handshake.
- A `start` pulse in the middle of a run exposes a controller that restarts and clears a live run.
- Checks taken one cycle after each update, and on the cycle after `done`, expose split update timing and a done pulse that lasts more than one cycle.

// File: rtl/thresh_tally.sv
module thresh_tally #(
  parameter int W     = 8,
  parameter int LIMIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  output logic         in_ready,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum_out,
  output logic [W-1:0] cnt_out
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_UPD, S_DONE} state_t;

  state_t       st;
  logic [W-1:0] xr, sum_r, cnt_r;
  logic         hit, last;

  assign hit  = xr > LIM;
  assign last = xr == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      xr    <= '0;
      sum_r <= '0;
      cnt_r <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          sum_r <= '0;
          cnt_r <= '0;
          st    <= S_READ;
        end
        S_READ: if (in_valid) begin
          xr <= in_x;
          st <= S_UPD;
        end
        S_UPD: begin
          if (hit) begin
            cnt_r <= cnt_r + 1'b1;
            sum_r <= sum_r + xr;
          end
          st <= last ? S_DONE : S_READ;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready = st == S_READ;
  assign busy     = st != S_IDLE;
  assign done     = st == S_DONE;
  assign sum_out  = sum_r;
  assign cnt_out  = cnt_r;
endmodule

module thresh_tally_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         in_valid,
  input logic [W-1:0] in_x,
  input logic         in_ready,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] sum_out,
  input logic [W-1:0] cnt_out
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (sum_out == '0 && cnt_out == '0 && in_ready));

  // R4
  joint_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(cnt_out)) |-> !$stable(sum_out));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_out == $past(cnt_out) || cnt_out == $past(cnt_out) + W'(1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum_out) && $stable(cnt_out)));

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !done));
endmodule

bind thresh_tally thresh_tally_chk #(.W(W)) u_chk (.*);

// File: tb/tb_thresh_tally.sv
module tb_thresh_tally;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       in_valid = 0;
  logic [7:0] in_x = '0;
  logic       in_ready, busy, done;
  logic [7:0] sum_out, cnt_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int exp_sum = 0;
  int exp_cnt = 0;

  thresh_tally dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_run();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    exp_sum = 0;
    exp_cnt = 0;
    // R2
    chk("R2 sum cleared", sum_out, 0);
    chk("R2 cnt cleared", cnt_out, 0);
    chk("R2 ready", in_ready, 1);
  endtask

  task automatic push(input int x, input bit junk, input bit live);
    while (!in_ready) @(negedge clk);
    in_valid = 1;
    in_x = 8'(x);
    @(negedge clk);
    in_valid = junk;
    in_x = 8'd200;
    if (x > 10) begin
      exp_cnt = (exp_cnt + 1) % 256;
      exp_sum = (exp_sum + x) % 256;
    end
    @(negedge clk);
    in_valid = 0;
    if (live) begin
      // R4: both outputs updated together at the second edge after acceptance
      chk("R4 live cnt", cnt_out, exp_cnt);
      chk("R4 live sum", sum_out, exp_sum);
    end
  endtask

  task automatic finish_run();
    int n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    // R5
    chk("R5 done seen", done, 1);
    chk("R5 final sum", sum_out, exp_sum);
    chk("R5 final cnt", cnt_out, exp_cnt);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", in_ready, 0);
    chk("R1 sum", sum_out, 0);
    chk("R1 cnt", cnt_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: sweep every single nonzero value, then terminate with zero
    for (int v = 1; v < 256; v++) begin
      begin_run();
      push(v, 0, 0);
      push(0, 0, 0);
      finish_run();
      chk("R3 tally threshold", cnt_out, (v > 10) ? 1 : 0);
      chk("R3 sum threshold", sum_out, (v > 10) ? v : 0);
    end

    // R3 boundary run and R4 live checks
    begin_run();
    push(10, 0, 1);
    push(11, 0, 1);
    push(3, 0, 1);
    push(12, 0, 1);
    push(0, 0, 1);
    finish_run();
    chk("R3 boundary cnt", cnt_out, 2);
    chk("R3 boundary sum", sum_out, 23);

    // R7: sum wraps
    begin_run();
    push(200, 0, 1);
    push(100, 0, 1);
    push(0, 0, 1);
    finish_run();
    chk("R7 sum wrap", sum_out, 44);
    chk("R7 cnt", cnt_out, 2);

    // R7: count wraps after 257 samples
    begin_run();
    for (int i = 0; i < 257; i++) push(11, 0, 0);
    push(0, 0, 0);
    finish_run();
    chk("R7 cnt wrap", cnt_out, 1);
    chk("R7 sum wrap many", sum_out, 11);

    // R8: in_valid asserted while in_ready is low is ignored
    begin_run();
    push(20, 1, 1);
    push(5, 1, 1);
    push(30, 1, 1);
    push(0, 1, 1);
    finish_run();
    chk("R8 junk ignored cnt", cnt_out, 2);
    chk("R8 junk ignored sum", sum_out, 50);

    // R6 and R8: idle hold with stray in_valid
    @(negedge clk);
    in_valid = 1;
    in_x = 8'd99;
    repeat (5) @(negedge clk);
    in_valid = 0;
    chk("R6 hold sum", sum_out, 50);
    chk("R6 hold cnt", cnt_out, 2);
    chk("R8 idle busy", busy, 0);

    // R9: start mid-run is ignored
    begin_run();
    push(40, 0, 1);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R9 mid-run cnt kept", cnt_out, 1);
    chk("R9 mid-run sum kept", sum_out, 40);
    push(50, 0, 1);
    push(0, 0, 1);
    finish_run();
    chk("R9 final sum", sum_out, 90);
    chk("R9 final cnt", cnt_out, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule